// File: doc/BRIEF.md
# Accumulator Readout Scaler and Saturator

This block holds one 56-bit DSP accumulator and provides both of its bus-facing paths. The accumulator consists of an 8-bit extension field, a 24-bit high word and a 24-bit low word. On the write side, a full-accumulator write of a 24-bit word or a 48-bit long word is extended automatically. A write aimed at a single field stores the data as given, with no extension.

On the read side, a full-accumulator read is shifted first, by the scaling mode, by one bit in either direction or not at all. The shifted value is then checked against the range of the bus word. A value outside that range is replaced by the matching saturation constant, and a limit strobe is raised for the sticky limit flag held elsewhere. Reading a single field bypasses both the shift and the saturation. Saturation changes only the copy that goes onto the bus and never the stored accumulator. The read path is purely combinational from the stored value and the read controls.

Top module: `acc_readout_sat`

## Requirements
- R1: After reset the accumulator holds zero, so every field read returns zero.
- R2: A full-accumulator word write (select 00, long low) stores wr_data[23:0] in the high word, clears the low word, and fills the extension with copies of wr_data[23].
- R3: A full-accumulator long write (select 00, long high) stores wr_data[47:0] in high:low words and fills the extension with copies of wr_data[47].
- R4: A field write changes only the named field and performs no extension. Select 01 is the low word, 10 the high word and 11 the extension; the extension takes wr_data[7:0].
- R5: Reading a field (select 01, 10 or 11) returns its raw bits zero-padded in rd_data, with limit_hit low, for every scaling mode and size.
- R6: Scaling mode 00 leaves the value unshifted, 01 shifts it one bit arithmetically right, and 10 shifts it one bit arithmetically left. Reserved mode 11 behaves as 00.
- R7: On a full read, a word transfer returns bits 47:24 of the scaled value in rd_data[23:0], with the upper bits zero. A long transfer returns bits 47:0.
- R8: A scaled value outside the signed 48-bit range counts as overflow. A word read then returns 0x7FFFFF for a positive value and 0x800000 for a negative one, and raises limit_hit.
- R9: On overflow, a long read returns 0x7FFFFFFFFFFF for a positive value and 0x800000000000 for a negative one, and raises limit_hit.
- R10: Limiting never alters the stored accumulator.
- R11: Scaling is applied before the range check. A value that fits unscaled can saturate after an up-shift, and a value that overflows unscaled can fit after a down-shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 00 full, 01 low word, 10 high word, 11 extension |
| wr_long | input | 1 | Full write size: 1 long word, 0 word |
| wr_data | input | 48 | Write data |
| rd_sel | input | 2 | Read source, same coding as wr_sel |
| rd_long | input | 1 | Full read size: 1 long word, 0 word |
| scale_mode | input | 2 | Scaling mode |
| rd_data | output | 48 | Bus value |
| limit_hit | output | 1 | Saturation occurred on this read |

## Verification
The bench loads values that sit on the edge of the bus range and reads each one under all four scaling modes and both sizes.

An up-shift that drops the sign bit would let 0x00_400000_000000 pass as a negative number instead of saturating. A range check made before scaling would fail on both of the order cases in R11.

Field reads of a saturating value confirm that neither the shift nor the constant reaches them, and that the stored value survives. Writes of negative words and long words expose a design that extends from the wrong bit or leaves stale low bits behind.

// File: rtl/acc_rd_pkg.sv
package acc_rd_pkg;
    typedef enum logic [1:0] {
        SRC_FULL = 2'b00,
        SRC_LOW  = 2'b01,
        SRC_HIGH = 2'b10,
        SRC_EXT  = 2'b11
    } acc_src_e;

    typedef enum logic [1:0] {
        SCL_NONE = 2'b00,
        SCL_DOWN = 2'b01,
        SCL_UP   = 2'b10,
        SCL_RSVD = 2'b11
    } scale_e;
endpackage

// File: rtl/acc_store.sv
module acc_store
    import acc_rd_pkg::*;
#(
    parameter int EXT_W  = 8,
    parameter int WORD_W = 24,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_long,
    input  logic [LONG_W-1:0] wr_data,
    output logic [ACC_W-1:0]  acc_q
);
    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_fields_t;

    acc_fields_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (acc_src_e'(wr_sel))
                SRC_FULL: begin
                    if (wr_long) begin
                        st_d.hi  = wr_data[LONG_W-1:WORD_W];
                        st_d.lo  = wr_data[WORD_W-1:0];
                        st_d.ext = {EXT_W{wr_data[LONG_W-1]}};
                    end else begin
                        st_d.hi  = wr_data[WORD_W-1:0];
                        st_d.lo  = '0;
                        st_d.ext = {EXT_W{wr_data[WORD_W-1]}};
                    end
                end
                SRC_LOW:  st_d.lo  = wr_data[WORD_W-1:0];
                SRC_HIGH: st_d.hi  = wr_data[WORD_W-1:0];
                SRC_EXT:  st_d.ext = wr_data[EXT_W-1:0];
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q = st_q;

    // R2: word write zero-fills the low word and extends from the new high word
    a_r2_word_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00 && !wr_long) |=>
        (st_q.lo == '0 && st_q.ext == {EXT_W{st_q.hi[WORD_W-1]}}
         && st_q.hi == $past(wr_data[WORD_W-1:0])));

    // R3: long write extends from bit 47
    a_r3_long_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00 && wr_long) |=>
        (st_q.ext == {EXT_W{st_q.hi[WORD_W-1]}}
         && {st_q.hi, st_q.lo} == $past(wr_data)));

    // R4: extension write leaves both words alone
    a_r4_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R4: high-word write performs no extension
    a_r4_hi_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10) |=> ($stable(st_q.ext) && $stable(st_q.lo)));
endmodule

// File: rtl/acc_scaler.sv
module acc_scaler
    import acc_rd_pkg::*;
#(
    parameter int ACC_W = 56
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [1:0]       mode,
    output logic [ACC_W:0]   scaled
);
    // One guard bit above the accumulator keeps the true sign after an up-shift.
    always_comb begin
        case (scale_e'(mode))
            SCL_DOWN: scaled = {acc_in[ACC_W-1], acc_in[ACC_W-1], acc_in[ACC_W-1:1]};
            SCL_UP:   scaled = {acc_in, 1'b0};
            default:  scaled = {acc_in[ACC_W-1], acc_in};
        endcase
    end
endmodule

// File: rtl/acc_limiter.sv
module acc_limiter #(
    parameter int ACC_W  = 56,
    parameter int WORD_W = 24,
    localparam int LONG_W = 2 * WORD_W,
    localparam int TOP_W  = ACC_W + 1 - (LONG_W - 1)
) (
    input  logic [ACC_W:0]    scaled,
    input  logic              long_sel,
    input  logic              en,
    output logic [LONG_W-1:0] bus,
    output logic              limit
);
    localparam logic [LONG_W-1:0] POS_LONG = {1'b0, {(LONG_W-1){1'b1}}};
    localparam logic [LONG_W-1:0] NEG_LONG = {1'b1, {(LONG_W-1){1'b0}}};
    localparam logic [LONG_W-1:0] POS_WORD = {{WORD_W{1'b0}}, 1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [LONG_W-1:0] NEG_WORD = {{WORD_W{1'b0}}, 1'b1, {(WORD_W-1){1'b0}}};

    logic [TOP_W-1:0] top_bits;
    logic             ovf;
    logic             neg;

    assign top_bits = scaled[ACC_W:LONG_W-1];
    assign ovf      = !((&top_bits) || !(|top_bits));
    assign neg      = scaled[ACC_W];

    always_comb begin
        if (ovf) begin
            if (long_sel) bus = neg ? NEG_LONG : POS_LONG;
            else          bus = neg ? NEG_WORD : POS_WORD;
        end else begin
            if (long_sel) bus = scaled[LONG_W-1:0];
            else          bus = {{WORD_W{1'b0}}, scaled[LONG_W-1:WORD_W]};
        end
    end

    assign limit = en && ovf;
endmodule

// File: rtl/acc_readout_sat.sv
module acc_readout_sat
    import acc_rd_pkg::*;
#(
    parameter int EXT_W  = 8,
    parameter int WORD_W = 24,
    localparam int LONG_W = 2 * WORD_W,
    localparam int ACC_W  = EXT_W + LONG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_long,
    input  logic [LONG_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic              rd_long,
    input  logic [1:0]        scale_mode,
    output logic [LONG_W-1:0] rd_data,
    output logic              limit_hit
);
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W:0]    scaled;
    logic [LONG_W-1:0] full_bus;
    logic              full_sel;

    assign full_sel = (acc_src_e'(rd_sel) == SRC_FULL);

    acc_store #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_long (wr_long),
        .wr_data (wr_data),
        .acc_q   (acc_q)
    );

    acc_scaler #(.ACC_W(ACC_W)) u_scale (
        .acc_in (acc_q),
        .mode   (scale_mode),
        .scaled (scaled)
    );

    acc_limiter #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_limit (
        .scaled   (scaled),
        .long_sel (rd_long),
        .en       (full_sel),
        .bus      (full_bus),
        .limit    (limit_hit)
    );

    always_comb begin
        case (acc_src_e'(rd_sel))
            SRC_LOW:  rd_data = {{WORD_W{1'b0}}, acc_q[WORD_W-1:0]};
            SRC_HIGH: rd_data = {{WORD_W{1'b0}}, acc_q[LONG_W-1:WORD_W]};
            SRC_EXT:  rd_data = {{(LONG_W-EXT_W){1'b0}}, acc_q[ACC_W-1:LONG_W]};
            default:  rd_data = full_bus;
        endcase
    end

    // R5: field reads never saturate
    a_r5_field_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != 2'b00) |-> !limit_hit);

    // R10: a saturating read leaves the stored value untouched
    a_r10_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hit && !wr_en) |=> $stable(acc_q));

    // R8: word saturation drives only the two word constants
    a_r8_word_const: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hit && !rd_long) |->
        (rd_data == {{WORD_W{1'b0}}, 1'b0, {(WORD_W-1){1'b1}}} ||
         rd_data == {{WORD_W{1'b0}}, 1'b1, {(WORD_W-1){1'b0}}}));

    // R9: long saturation drives only the two long constants
    a_r9_long_const: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hit && rd_long) |->
        (rd_data == {1'b0, {(LONG_W-1){1'b1}}} ||
         rd_data == {1'b1, {(LONG_W-1){1'b0}}}));

    // R6: unscaled long read without overflow is the raw low 48 bits
    a_r6_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (full_sel && scale_mode == 2'b00 && rd_long && !limit_hit) |->
        (rd_data == acc_q[LONG_W-1:0]));
endmodule

// File: tb/sim_acc_readout_sat.sv
module sim_acc_readout_sat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic        wr_long = 1'b0;
    logic [47:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'b00;
    logic        rd_long = 1'b0;
    logic [1:0]  scale_mode = 2'b00;
    logic [47:0] rd_data;
    logic        limit_hit;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acc_readout_sat u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_long(wr_long), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_long(rd_long), .scale_mode(scale_mode),
        .rd_data(rd_data), .limit_hit(limit_hit)
    );

    task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic lng, input logic [47:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_long = lng; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_acc(input logic [55:0] a);
        do_write(2'b00, 1'b1, a[47:0]);
        do_write(2'b11, 1'b0, {40'h0, a[55:48]});
    endtask

    task automatic do_read(input logic [1:0] sel, input logic lng, input logic [1:0] mode,
                           output logic [47:0] d, output logic l);
        @(negedge clk);
        rd_sel = sel; rd_long = lng; scale_mode = mode;
        #2;
        d = rd_data; l = limit_hit;
    endtask

    function automatic void model(input logic [55:0] a, input logic lng, input logic [1:0] mode,
                                  output logic [47:0] d, output logic l);
        longint v;
        longint hi = 64'sh0000_7FFF_FFFF_FFFF;
        longint lo = -64'sh0000_8000_0000_0000;
        v = {{8{a[55]}}, a};
        if (mode == 2'b01) v = v >>> 1;
        else if (mode == 2'b10) v = v <<< 1;
        l = (v > hi) || (v < lo);
        if (lng) d = (v > hi) ? 48'h7FFF_FFFF_FFFF : (v < lo) ? 48'h8000_0000_0000 : v[47:0];
        else     d = (v > hi) ? 48'h7FFFFF : (v < lo) ? 48'h800000 : {24'h0, v[47:24]};
    endfunction

    task automatic chk_full(input string req, input logic [55:0] a, input logic lng, input logic [1:0] mode);
        logic [47:0] d, de;
        logic l, le;
        model(a, lng, mode, de, le);
        do_read(2'b00, lng, mode, d, l);
        chk(req, {8'h0, d}, {8'h0, de});
        chk(req, {55'h0, l}, {55'h0, le});
    endtask

    task automatic chk_fields(input string req, input logic [55:0] a);
        logic [47:0] d;
        logic l;
        do_read(2'b01, 1'b0, 2'b00, d, l); chk(req, {8'h0, d}, {32'h0, a[23:0]});
        do_read(2'b10, 1'b0, 2'b00, d, l); chk(req, {8'h0, d}, {32'h0, a[47:24]});
        do_read(2'b11, 1'b0, 2'b00, d, l); chk(req, {8'h0, d}, {48'h0, a[55:48]});
    endtask

    task automatic t_reset;
        chk_fields("R1", 56'h0);
    endtask

    task automatic t_word_write;
        load_acc(56'h12_345678_9ABCDE);
        do_write(2'b00, 1'b0, 48'h0000_0080_0001);
        chk_fields("R2", 56'hFF_800001_000000);
        do_write(2'b00, 1'b0, 48'hFFFF_FF7F_FFFE);
        chk_fields("R2", 56'h00_7FFFFE_000000);
    endtask

    task automatic t_long_write;
        do_write(2'b00, 1'b1, 48'h8000_0000_1234);
        chk_fields("R3", 56'hFF_800000_001234);
        do_write(2'b00, 1'b1, 48'h7FFF_FFFF_FFFF);
        chk_fields("R3", 56'h00_7FFFFF_FFFFFF);
    endtask

    task automatic t_field_write;
        load_acc(56'h00_111111_222222);
        do_write(2'b01, 1'b0, 48'h0000_00AB_CDEF);
        chk_fields("R4", 56'h00_111111_ABCDEF);
        do_write(2'b10, 1'b0, 48'h0000_0080_0000);
        chk_fields("R4", 56'h00_800000_ABCDEF);
        do_write(2'b11, 1'b0, 48'h0000_0000_005A);
        chk_fields("R4", 56'h5A_800000_ABCDEF);
    endtask

    task automatic t_bypass;
        logic [55:0] a = 56'h7F_C00000_800001;
        logic [47:0] d;
        logic l;
        load_acc(a);
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                do_read(2'b01, s[0], m[1:0], d, l);
                chk("R5", {8'h0, d}, {32'h0, a[23:0]}); chk("R5", {55'h0, l}, 56'h0);
                do_read(2'b10, s[0], m[1:0], d, l);
                chk("R5", {8'h0, d}, {32'h0, a[47:24]}); chk("R5", {55'h0, l}, 56'h0);
                do_read(2'b11, s[0], m[1:0], d, l);
                chk("R5", {8'h0, d}, {48'h0, a[55:48]}); chk("R5", {55'h0, l}, 56'h0);
            end
        end
    endtask

    task automatic t_sweep;
        logic [55:0] vals [11] = '{56'h00_7FFFFF_FFFFFF, 56'hFF_800000_000000,
            56'h00_400000_000000, 56'hFF_BFFFFF_FFFFFF, 56'h00_800000_000000,
            56'h01_000000_000000, 56'hFF_000000_000000, 56'h7F_FFFFFF_FFFFFF,
            56'h80_000000_000000, 56'h00_000000_000001, 56'hFF_FFFFFF_FFFFFF};
        for (int i = 0; i < 11; i++) begin
            load_acc(vals[i]);
            for (int m = 0; m < 4; m++) begin
                chk_full("R6", vals[i], 1'b1, m[1:0]);
                chk_full("R7", vals[i], 1'b0, m[1:0]);
            end
        end
    endtask

    task automatic t_sat_word;
        logic [47:0] d;
        logic l;
        load_acc(56'h01_000000_000000);
        do_read(2'b00, 1'b0, 2'b00, d, l);
        chk("R8", {8'h0, d}, 56'h7FFFFF); chk("R8", {55'h0, l}, 56'h1);
        load_acc(56'hFE_123456_000000);
        do_read(2'b00, 1'b0, 2'b00, d, l);
        chk("R8", {8'h0, d}, 56'h800000); chk("R8", {55'h0, l}, 56'h1);
    endtask

    task automatic t_sat_long;
        logic [47:0] d;
        logic l;
        load_acc(56'h01_000000_000000);
        do_read(2'b00, 1'b1, 2'b00, d, l);
        chk("R9", {8'h0, d}, 56'h7FFF_FFFF_FFFF); chk("R9", {55'h0, l}, 56'h1);
        load_acc(56'hFE_123456_000000);
        do_read(2'b00, 1'b1, 2'b00, d, l);
        chk("R9", {8'h0, d}, 56'h8000_0000_0000); chk("R9", {55'h0, l}, 56'h1);
    endtask

    task automatic t_order;
        logic [47:0] d;
        logic l;
        load_acc(56'h00_400000_000000);
        do_read(2'b00, 1'b0, 2'b00, d, l);
        chk("R11", {8'h0, d}, 56'h400000); chk("R11", {55'h0, l}, 56'h0);
        do_read(2'b00, 1'b0, 2'b10, d, l);
        chk("R11", {8'h0, d}, 56'h7FFFFF); chk("R11", {55'h0, l}, 56'h1);
        load_acc(56'h00_800000_000000);
        do_read(2'b00, 1'b0, 2'b00, d, l);
        chk("R11", {8'h0, d}, 56'h7FFFFF); chk("R11", {55'h0, l}, 56'h1);
        do_read(2'b00, 1'b0, 2'b01, d, l);
        chk("R11", {8'h0, d}, 56'h400000); chk("R11", {55'h0, l}, 56'h0);
    endtask

    task automatic t_kept;
        logic [47:0] d;
        logic l;
        load_acc(56'h3C_A5A5A5_5A5A5A);
        do_read(2'b00, 1'b1, 2'b10, d, l);
        chk("R10", {55'h0, l}, 56'h1);
        do_read(2'b00, 1'b0, 2'b00, d, l);
        chk_fields("R10", 56'h3C_A5A5A5_5A5A5A);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_write();
        t_long_write();
        t_field_write();
        t_bypass();
        t_sweep();
        t_sat_word();
        t_sat_long();
        t_order();
        t_kept();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule